// File: doc/BRIEF.md
# Strapped-Address I2C Register Slave

This block is an I2C slave that gives an external master access to a register file of 256 byte-wide locations. It runs from a system clock much faster than SCL. Both bus lines go through a synchronizer and a glitch filter, and the block watches the filtered lines for START, STOP and clock edges. SDA is open-drain: the block only ever pulls the line low, through an output enable.

One strap input chooses between two fixed device addresses. A write transfer sends an 8-bit subaddress and then any number of data bytes. Each data byte appears on the register-file write port as a one-cycle strobe, together with the current subaddress. A read transfer first sets the subaddress with a write, then issues a repeated START with the read address. The slave then shifts out the byte that the register file returns for the current subaddress. The subaddress steps by one after every data byte in either direction and wraps from FFh to 00h.

The register file sits outside the block. It decodes `reg_addr` and returns its contents on `reg_rdata` combinationally.

Top module: `i2c_regif_slave`

## Requirements
- R1: With `addr_sel` low, the slave acknowledges the address byte B0h (write, R/W bit 0 in bit position 0) and B1h (read). It acknowledges no other address byte.
- R2: With `addr_sel` high, the slave acknowledges B2h (write) and B3h (read). It acknowledges no other address byte.
- R3: After an address byte that does not match, the slave never drives SDA low and produces no write strobe until the next START or STOP.
- R4: In a write transfer, the slave acknowledges the subaddress and every data byte. Each data byte produces exactly one single-cycle `reg_we` pulse, with that byte on `reg_wdata` and the current subaddress on `reg_addr`.
- R5: The subaddress increments by one after every data byte, in write and read transfers alike, and wraps from FFh to 00h.
- R6: In a read transfer entered through a repeated START, every data byte equals `reg_rdata` for the current subaddress and is sent MSB first.
- R7: When the master NACKs a read byte, the slave releases SDA. It drives nothing further until the next START.
- R8: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks is ignored. It causes no bit, START or STOP.
- R9: Transfers complete correctly at 100 kHz and 400 kHz SCL with a 100 MHz system clock.
- R10: While reset is held and right after it, `sda_oe` and `reg_we` are low.
- R11: A STOP in the middle of a transfer returns the slave to idle, with SDA released. A repeated START re-enters the address phase and keeps the current subaddress. SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 1 | Strap that picks one of the two device addresses |
| scl_i | input | 1 | SCL line as seen on the pad |
| sda_i | input | 1 | SDA line as seen on the pad |
| sda_oe | output | 1 | When high, pulls SDA low; when low, SDA is released |
| reg_addr | output | 8 | Current subaddress, used for both reads and writes |
| reg_wdata | output | 8 | Byte to write into the register file |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Register-file contents at `reg_addr` |

## Verification
The hardest case to reach is a repeated START that arrives right after a write has moved the subaddress. The read that follows must start from the incremented location, not from the one the master sent. The bench reaches this case with a single write byte followed directly by a repeated START. It also injects SCL and SDA pulses of less than the filter length in the middle of a byte. These pulses would otherwise look like an extra clock or a false STOP.

// File: rtl/i2c_regif_pkg.sv
package i2c_regif_pkg;

    localparam int BYTE_W = 8;
    localparam int DEV_W  = 7;

    localparam logic [DEV_W-1:0] DEV_ID_STRAP_LO = 7'h58;
    localparam logic [DEV_W-1:0] DEV_ID_STRAP_HI = 7'h59;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_SUB,
        PH_SUB_ACK,
        PH_WR,
        PH_WR_ACK,
        PH_RD,
        PH_RD_ACK
    } phase_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    function automatic logic [DEV_W-1:0] dev_id(input logic strap);
        return strap ? DEV_ID_STRAP_HI : DEV_ID_STRAP_LO;
    endfunction

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt;
    logic                   sampled;

    assign sampled = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            cnt    <= '0;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            if (sampled == dout) begin
                cnt <= '0;
            end else if (cnt == CNT_W'(FILT_LEN - 1)) begin
                dout <= sampled;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import i2c_regif_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_t     line,
    output bus_evt_t evt
);
    bus_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '{scl: 1'b1, sda: 1'b1};
        else     prev <= line;
    end

    always_comb begin
        evt.start    = line.scl & prev.scl & prev.sda & ~line.sda;
        evt.stop     = line.scl & prev.scl & ~prev.sda & line.sda;
        evt.scl_rise = line.scl & ~prev.scl;
        evt.scl_fall = ~line.scl & prev.scl;
        evt.sda      = line.sda;
    end
endmodule

// File: rtl/i2c_regif_slave.sv
module i2c_regif_slave
    import i2c_regif_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_sel,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam int BIT_CW = $clog2(BYTE_W + 1);

    logic [1:0] raw_lines;
    logic [1:0] clean_lines;
    bus_t       line;
    bus_evt_t   evt;

    assign raw_lines = {scl_i, sda_i};

    for (genvar gi = 0; gi < 2; gi++) begin : g_line
        i2c_glitch_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk (clk),
            .rst (rst),
            .din (raw_lines[gi]),
            .dout(clean_lines[gi])
        );
    end

    assign line = '{scl: clean_lines[1], sda: clean_lines[0]};

    i2c_bus_events u_evt (
        .clk (clk),
        .rst (rst),
        .line(line),
        .evt (evt)
    );

    phase_t            phase;
    logic [BIT_CW-1:0] bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic [BYTE_W-1:0] subaddr;
    logic              rd_dir;
    logic              mack;
    logic              byte_done;

    assign byte_done = evt.scl_fall && (bitcnt == BIT_CW'(BYTE_W));
    assign reg_addr  = subaddr;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            txreg     <= '0;
            subaddr   <= '0;
            rd_dir    <= 1'b0;
            mack      <= 1'b0;
            sda_oe    <= 1'b0;
            reg_we    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            if (reg_we) subaddr <= subaddr + 1'b1;

            if (evt.start) begin
                phase  <= PH_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (phase)
                    PH_ADDR, PH_SUB, PH_WR: begin
                        if (evt.scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], evt.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_done) begin
                            bitcnt <= '0;
                            if (phase == PH_ADDR) begin
                                if (shreg[BYTE_W-1:1] == dev_id(addr_sel)) begin
                                    rd_dir <= shreg[0];
                                    sda_oe <= 1'b1;
                                    phase  <= PH_ADDR_ACK;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end else if (phase == PH_SUB) begin
                                subaddr <= shreg;
                                sda_oe  <= 1'b1;
                                phase   <= PH_SUB_ACK;
                            end else begin
                                reg_we    <= 1'b1;
                                reg_wdata <= shreg;
                                sda_oe    <= 1'b1;
                                phase     <= PH_WR_ACK;
                            end
                        end
                    end
                    PH_ADDR_ACK, PH_SUB_ACK, PH_WR_ACK: begin
                        if (evt.scl_fall) begin
                            bitcnt <= '0;
                            if (phase == PH_ADDR_ACK && rd_dir) begin
                                txreg  <= reg_rdata;
                                sda_oe <= ~reg_rdata[BYTE_W-1];
                                phase  <= PH_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                phase  <= (phase == PH_ADDR_ACK) ? PH_SUB : PH_WR;
                            end
                        end
                    end
                    PH_RD: begin
                        if (evt.scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_done) begin
                            sda_oe  <= 1'b0;
                            subaddr <= subaddr + 1'b1;
                            phase   <= PH_RD_ACK;
                        end else if (evt.scl_fall) begin
                            sda_oe <= ~txreg[BYTE_W-2];
                            txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                        end
                    end
                    PH_RD_ACK: begin
                        if (evt.scl_rise) begin
                            mack <= ~evt.sda;
                        end else if (evt.scl_fall) begin
                            bitcnt <= '0;
                            if (mack) begin
                                txreg  <= reg_rdata;
                                sda_oe <= ~reg_rdata[BYTE_W-1];
                                phase  <= PH_RD;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_regif_slave_chk.sv
module i2c_regif_slave_chk
    import i2c_regif_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sda_oe,
    input logic              reg_we,
    input logic [BYTE_W-1:0] reg_addr,
    input logic              scl_f,
    input logic              stop_evt,
    input phase_t            phase
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!sda_oe && !reg_we)); // R10

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we); // R4

    AST_SUBADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> (reg_addr == $past(reg_addr) + 8'd1)); // R5

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_f); // R11

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !sda_oe); // R11

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> !reg_we); // R3

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && $past(phase) == PH_IDLE) |-> !sda_oe); // R3
endmodule

bind i2c_regif_slave i2c_regif_slave_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .sda_oe  (sda_oe),
    .reg_we  (reg_we),
    .reg_addr(reg_addr),
    .scl_f   (line.scl),
    .stop_evt(evt.stop),
    .phase   (phase)
);

// File: tb/tb_i2c_regif_slave.sv
module tb_i2c_regif_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q_FAST     = 8;
    localparam int Q_400K     = 62;
    localparam int Q_100K     = 250;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr_sel = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_oe;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_regif_slave dut (
        .clk      (clk),
        .rst      (rst),
        .addr_sel (addr_sel),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_we   (reg_we),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 7 + 3) ^ 8'h5A);
    endfunction

    logic [7:0] regs [256];
    logic [7:0] exp_mem [256];
    logic [7:0] wa [64];
    logic [7:0] wd [64];
    int wr_cnt  = 0;
    int oe_cyc  = 0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) regs[i] <= init_val(i);
        end else if (reg_we) begin
            regs[reg_addr] <= reg_wdata;
        end
    end
    assign reg_rdata = regs[reg_addr];

    always @(posedge clk) begin
        if (!rst && reg_we && wr_cnt < 64) begin
            wa[wr_cnt] <= reg_addr;
            wd[wr_cnt] <= reg_wdata;
            wr_cnt     <= wr_cnt + 1;
        end
        if (sda_oe) oe_cyc <= oe_cyc + 1;
    end

    int checks = 0;
    int fails  = 0;
    int q      = Q_FAST;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    // glitch: 0 none, 1 SDA pulse while SCL high, 2 SCL pulse while SCL low
    task automatic send_bit(input logic b, input int glitch);
        sda_m = b;
        if (glitch == 2) begin
            repeat (q/2) @(posedge clk);
            #1 scl_m = 1'b1;
            repeat (2) @(posedge clk);
            #1 scl_m = 1'b0;
            repeat (q - q/2 - 2) @(posedge clk);
            #1;
        end else begin
            wq();
        end
        scl_m = 1'b1; wq();
        if (glitch == 1) begin
            sda_m = ~b;
            repeat (2) @(posedge clk);
            #1 sda_m = b;
        end
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        b = sda_bus;  wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] d, input int glitch, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i], (i == 3) ? glitch : 0);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~give_ack, 0);
    endtask

    task automatic do_write(input logic [7:0] dev, input logic [7:0] sub,
                            input logic [7:0] d0, input int n, input int glitch);
        bit ack;
        bus_start();
        send_byte(dev, 0, ack);
        chk(ack, "R4 dev ack", ack, 1);
        send_byte(sub, 0, ack);
        chk(ack, "R4 sub ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(8'(d0 + k), glitch, ack);
            chk(ack, "R4 data ack", ack, 1);
            exp_mem[8'(sub + k)] = 8'(d0 + k);
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] dev, input logic [7:0] sub,
                           input int n, input string req);
        bit ack;
        logic [7:0] d;
        bus_start();
        send_byte(dev, 0, ack);
        send_byte(sub, 0, ack);
        bus_start();
        send_byte(dev | 8'h01, 0, ack);
        chk(ack, req, ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(d, k != n - 1);
            chk(d == exp_mem[8'(sub + k)], req, d, exp_mem[8'(sub + k)]);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit ack;
        int w0, o0;
        logic [7:0] d;
        logic b;
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);

        repeat (5) @(posedge clk);
        #1;
        chk(sda_oe == 1'b0 && reg_we == 1'b0, "R10 during reset", {sda_oe, reg_we}, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(sda_oe == 1'b0 && reg_we == 1'b0, "R10 after reset", {sda_oe, reg_we}, 0);

        // R1 / R2: sweep address bytes around both codes, both strap values
        for (int s = 0; s < 2; s++) begin
            addr_sel = s[0];
            q = Q_FAST;
            wq();
            for (int a = 8'hA8; a <= 8'hBF; a++) begin
                bit expect_ack;
                expect_ack = (a[7:1] == (s ? 7'h59 : 7'h58));
                w0 = wr_cnt;
                bus_start();
                send_byte(8'(a), 0, ack);
                chk(ack == expect_ack, s ? "R2 address match" : "R1 address match", ack, expect_ack);
                if (ack && a[0]) recv_byte(d, 1'b0);
                bus_stop();
                chk(wr_cnt == w0, "R3 no write on address only", wr_cnt - w0, 0);
            end
        end

        // R4, R9: write three bytes at 400 kHz
        addr_sel = 1'b0;
        q = Q_400K;
        w0 = wr_cnt;
        do_write(8'hB0, 8'h10, 8'hD1, 3, 0);
        chk(wr_cnt - w0 == 3, "R4 strobe count", wr_cnt - w0, 3);
        for (int k = 0; k < 3; k++) begin
            chk(wa[w0 + k] == 8'(8'h10 + k), "R4 write addr", wa[w0 + k], 8'h10 + k);
            chk(wd[w0 + k] == 8'(8'hD1 + k), "R4 write data", wd[w0 + k], 8'hD1 + k);
        end

        // R5: write wraps FFh -> 00h
        addr_sel = 1'b1;
        q = Q_FAST;
        w0 = wr_cnt;
        do_write(8'hB2, 8'hFE, 8'h61, 3, 0);
        chk(wa[w0] == 8'hFE && wa[w0 + 1] == 8'hFF && wa[w0 + 2] == 8'h00,
            "R5 write wrap", {wa[w0], wa[w0 + 1], wa[w0 + 2]}, 24'hFEFF00);

        // R6, R9: read three bytes at 100 kHz, last NACKed
        q = Q_100K;
        do_read(8'hB2, 8'h10, 3, "R6 read at 100k");
        bus_stop();

        // R5, R6, R7: read wrap, then check slave is silent after NACK
        q = Q_FAST;
        do_read(8'hB2, 8'hFF, 2, "R5 read wrap");
        o0 = oe_cyc;
        for (int k = 0; k < 9; k++) begin
            recv_bit(b);
            chk(b == 1'b1, "R7 released after NACK", b, 1);
        end
        chk(oe_cyc == o0, "R7 no drive after NACK", oe_cyc - o0, 0);
        bus_stop();

        // R3: wrong address then data bytes
        addr_sel = 1'b0;
        w0 = wr_cnt;
        o0 = oe_cyc;
        bus_start();
        send_byte(8'hB2, 0, ack);
        chk(!ack, "R3 foreign addr nack", ack, 0);
        send_byte(8'h05, 0, ack);
        chk(!ack, "R3 ignored sub", ack, 0);
        send_byte(8'h99, 0, ack);
        chk(!ack, "R3 ignored data", ack, 0);
        bus_stop();
        chk(oe_cyc == o0, "R3 no drive", oe_cyc - o0, 0);
        chk(wr_cnt == w0, "R3 no write", wr_cnt - w0, 0);

        // R11: STOP after subaddress, next transfer starts fresh
        w0 = wr_cnt;
        bus_start();
        send_byte(8'hB0, 0, ack);
        send_byte(8'h40, 0, ack);
        bus_stop();
        do_write(8'hB0, 8'h41, 8'h99, 1, 0);
        chk(wr_cnt - w0 == 1 && wa[w0] == 8'h41 && wd[w0] == 8'h99,
            "R11 stop resets phase", {wa[w0], wd[w0]}, 16'h4199);

        // R11, R5: one write byte then repeated START read continues at +1
        bus_start();
        send_byte(8'hB0, 0, ack);
        send_byte(8'h20, 0, ack);
        send_byte(8'h77, 0, ack);
        exp_mem[8'h20] = 8'h77;
        bus_start();
        send_byte(8'hB1, 0, ack);
        chk(ack, "R11 repeated start ack", ack, 1);
        recv_byte(d, 1'b0);
        chk(d == exp_mem[8'h21], "R11 sub kept across Sr", d, exp_mem[8'h21]);
        bus_stop();

        // R8: sub-filter pulses on SDA (SCL high) and SCL (SCL low)
        w0 = wr_cnt;
        do_write(8'hB0, 8'h30, 8'hC3, 1, 1);
        do_write(8'hB0, 8'h31, 8'h3C, 1, 2);
        chk(wr_cnt - w0 == 2, "R8 strobe count", wr_cnt - w0, 2);
        chk(wa[w0] == 8'h30 && wd[w0] == 8'hC3, "R8 SDA glitch", {wa[w0], wd[w0]}, 16'h30C3);
        chk(wa[w0 + 1] == 8'h31 && wd[w0 + 1] == 8'h3C, "R8 SCL glitch",
            {wa[w0 + 1], wd[w0 + 1]}, 16'h313C);
        do_read(8'hB0, 8'h30, 2, "R8 readback");
        bus_stop();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule